// File: doc/BRIEF.md
# Processor Mode Summary Cache

This block keeps a small register holding a pre-computed summary of the processor's execution mode. The summary has the current privilege level, the paging and protection enables, and log2-coded default and alternate sizes for operands and addresses, plus the stack width. Instruction decode only has to choose between a default and an alternate code. It never has to rebuild sizes from raw mode bits on every instruction.

Software updates the block through one register-write port, which carries an address select and a data word. Four addresses matter: the extended-feature register (long-mode-active bit), CR0, the code-segment attribute word and the stack-segment attribute word. The block keeps only the bits it needs from each one. A write to CR0 or to either attribute word recomputes the summary from the new value together with the stored values of the other registers, and it samples the current submode input at that moment. The new summary is visible on the cycle after the write.

Top module: `mode_cache_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are: `cpl`=0, `paging`=0, `prot`=0, `def_op`=1, `alt_op`=2, `def_addr`=1, `alt_addr`=2, `stack`=1.
- R2: After a recompute with long-mode-active stored as 1 (extended-feature register at select 0x0, bit 10):
  - `cpl` equals the code-segment DPL (attribute bits [1:0] at select 0x2).
  - `paging` equals CR0 bit 31 (select 0x1).
  - `prot` equals CR0 bit 0.
- R3: After a recompute with long mode active, if `sub64` is 1 or the code-segment default-size bit (attribute bit 2) is 1, then `def_op`/`alt_op` are 2/1. Otherwise they are 1/2.
- R4: After a recompute with long mode active, `def_addr`/`alt_addr` are:
  - 3/2 when `sub64` is 1;
  - otherwise 2/1 when the code-segment default-size bit is 1;
  - otherwise 1/2.
- R5: After a recompute with long mode active, `stack` is:
  - 3 when `sub64` is 1;
  - otherwise 2 when the stack-segment default-size bit (bit 2 of the word at select 0x3) is 1;
  - otherwise 1.
- R6: A write to select 0x1, 0x2 or 0x3 recomputes the summary. The recompute uses the written value for that register and the stored values for the others, and the result appears on the outputs on the next cycle.
- R7: A write to select 0x0 stores long-mode-active but does not change the outputs. A write to any select above 0x3 also leaves the outputs unchanged.
- R8: A recompute while the stored long-mode-active bit is 0 gives the R1 values.
- R9: With `wr_en` low, the outputs hold their values, including when `sub64` changes. `sub64` matters only at a recomputing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 32 | Write data |
| sub64 | input | 1 | Current submode is 64-bit |
| cpl | output | 2 | Current privilege level |
| paging | output | 1 | Paging enabled |
| prot | output | 1 | Protection enabled |
| def_op | output | 2 | Default operand size, log2 bytes |
| alt_op | output | 2 | Alternate operand size, log2 bytes |
| def_addr | output | 2 | Default address size, log2 bytes |
| alt_addr | output | 2 | Alternate address size, log2 bytes |
| stack | output | 2 | Stack width, log2 bytes |

## Verification
The hardest case to reach is the mix of a fresh written value with stale stored values. Examples are a stack-attribute write that must keep an older code-segment setting, and a submode change that must stay invisible until a later write. The bench first loads each register in a chosen order and toggles `sub64` with no write pending. It then triggers a recompute from a different register, so each output field is traced back to the write that should have set it.

// File: rtl/mode_cache_pkg.sv
package mode_cache_pkg;

  localparam int unsigned CODE_W = 2;

  typedef struct packed {
    logic [1:0]        cpl;
    logic              paging;
    logic              prot;
    logic [CODE_W-1:0] def_op;
    logic [CODE_W-1:0] alt_op;
    logic [CODE_W-1:0] def_addr;
    logic [CODE_W-1:0] alt_addr;
    logic [CODE_W-1:0] stack;
  } mode_summary_t;

  localparam logic [CODE_W-1:0] CODE_16 = 2'd1;
  localparam logic [CODE_W-1:0] CODE_32 = 2'd2;
  localparam logic [CODE_W-1:0] CODE_64 = 2'd3;

  localparam mode_summary_t SUMMARY_RESET = '{
    cpl: 2'd0, paging: 1'b0, prot: 1'b0,
    def_op: CODE_16, alt_op: CODE_32,
    def_addr: CODE_16, alt_addr: CODE_32,
    stack: CODE_16
  };

endpackage

// File: rtl/mcr_shadow_regs.sv
module mcr_shadow_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_ext,
  input  logic       ld_cr0,
  input  logic       ld_cs,
  input  logic       ld_ss,
  input  logic       new_lma,
  input  logic       new_pg,
  input  logic       new_pe,
  input  logic [1:0] new_dpl,
  input  logic       new_cs_big,
  input  logic       new_ss_big,
  output logic       lma_q,
  output logic       pg_q,
  output logic       pe_q,
  output logic [1:0] dpl_q,
  output logic       cs_big_q,
  output logic       ss_big_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lma_q <= 1'b0;
    end else if (ld_ext) begin
      lma_q <= new_lma;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      pe_q <= 1'b0;
    end else if (ld_cr0) begin
      pg_q <= new_pg;
      pe_q <= new_pe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpl_q    <= 2'd0;
      cs_big_q <= 1'b0;
    end else if (ld_cs) begin
      dpl_q    <= new_dpl;
      cs_big_q <= new_cs_big;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_big_q <= 1'b0;
    end else if (ld_ss) begin
      ss_big_q <= new_ss_big;
    end
  end

endmodule

// File: rtl/mcr_size_derive.sv
module mcr_size_derive
  import mode_cache_pkg::*;
(
  input  logic          lma,
  input  logic          pg,
  input  logic          pe,
  input  logic [1:0]    dpl,
  input  logic          cs_big,
  input  logic          ss_big,
  input  logic          sub64,
  output mode_summary_t summary
);

  always_comb begin
    summary = SUMMARY_RESET;
    if (lma) begin
      summary.cpl    = dpl;
      summary.paging = pg;
      summary.prot   = pe;

      if (sub64 || cs_big) begin
        summary.def_op = CODE_32;
        summary.alt_op = CODE_16;
      end else begin
        summary.def_op = CODE_16;
        summary.alt_op = CODE_32;
      end

      if (sub64) begin
        summary.def_addr = CODE_64;
        summary.alt_addr = CODE_32;
      end else if (cs_big) begin
        summary.def_addr = CODE_32;
        summary.alt_addr = CODE_16;
      end else begin
        summary.def_addr = CODE_16;
        summary.alt_addr = CODE_32;
      end

      if (sub64) begin
        summary.stack = CODE_64;
      end else if (ss_big) begin
        summary.stack = CODE_32;
      end else begin
        summary.stack = CODE_16;
      end
    end
  end

endmodule

// File: rtl/mcr_summary_reg.sv
module mcr_summary_reg
  import mode_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  mode_summary_t d,
  output mode_summary_t q
);

  mode_summary_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= SUMMARY_RESET;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/mode_cache_reg.sv
module mode_cache_reg
  import mode_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_EXT    = 0,
  parameter int unsigned SEL_CR0    = 1,
  parameter int unsigned SEL_CS     = 2,
  parameter int unsigned SEL_SS     = 3,
  parameter int unsigned LMA_BIT    = 10,
  parameter int unsigned PG_BIT     = 31,
  parameter int unsigned PE_BIT     = 0,
  parameter int unsigned DPL_LSB    = 0,
  parameter int unsigned CS_BIG_BIT = 2,
  parameter int unsigned SS_BIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sub64,
  output logic [1:0]        cpl,
  output logic              paging,
  output logic              prot,
  output logic [1:0]        def_op,
  output logic [1:0]        alt_op,
  output logic [1:0]        def_addr,
  output logic [1:0]        alt_addr,
  output logic [1:0]        stack
);

  localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(SEL_EXT);
  localparam logic [ADDR_W-1:0] A_CR0 = ADDR_W'(SEL_CR0);
  localparam logic [ADDR_W-1:0] A_CS  = ADDR_W'(SEL_CS);
  localparam logic [ADDR_W-1:0] A_SS  = ADDR_W'(SEL_SS);

  logic ld_ext, ld_cr0, ld_cs, ld_ss, recompute;
  logic unused_data;

  logic       lma_q, pg_q, pe_q, cs_big_q, ss_big_q;
  logic [1:0] dpl_q;

  logic       new_lma, new_pg, new_pe, new_cs_big, new_ss_big;
  logic [1:0] new_dpl;

  logic       eff_pg, eff_pe, eff_cs_big, eff_ss_big;
  logic [1:0] eff_dpl;

  mode_summary_t next_summary;
  mode_summary_t summary_q;

  // Write decode
  always_comb begin
    ld_ext    = wr_en && (wr_sel == A_EXT);
    ld_cr0    = wr_en && (wr_sel == A_CR0);
    ld_cs     = wr_en && (wr_sel == A_CS);
    ld_ss     = wr_en && (wr_sel == A_SS);
    recompute = ld_cr0 || ld_cs || ld_ss;
  end

  // Field extraction from the write data
  always_comb begin
    new_lma    = wr_data[LMA_BIT];
    new_pg     = wr_data[PG_BIT];
    new_pe     = wr_data[PE_BIT];
    new_dpl    = wr_data[DPL_LSB +: 2];
    new_cs_big = wr_data[CS_BIG_BIT];
    new_ss_big = wr_data[SS_BIG_BIT];
  end

  assign unused_data = ^wr_data;

  // Forward the register being written; keep the stored ones
  always_comb begin
    eff_pg     = ld_cr0 ? new_pg     : pg_q;
    eff_pe     = ld_cr0 ? new_pe     : pe_q;
    eff_dpl    = ld_cs  ? new_dpl    : dpl_q;
    eff_cs_big = ld_cs  ? new_cs_big : cs_big_q;
    eff_ss_big = ld_ss  ? new_ss_big : ss_big_q;
  end

  mcr_shadow_regs u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_ext     (ld_ext),
    .ld_cr0     (ld_cr0),
    .ld_cs      (ld_cs),
    .ld_ss      (ld_ss),
    .new_lma    (new_lma),
    .new_pg     (new_pg),
    .new_pe     (new_pe),
    .new_dpl    (new_dpl),
    .new_cs_big (new_cs_big),
    .new_ss_big (new_ss_big),
    .lma_q      (lma_q),
    .pg_q       (pg_q),
    .pe_q       (pe_q),
    .dpl_q      (dpl_q),
    .cs_big_q   (cs_big_q),
    .ss_big_q   (ss_big_q)
  );

  mcr_size_derive u_derive (
    .lma     (lma_q),
    .pg      (eff_pg),
    .pe      (eff_pe),
    .dpl     (eff_dpl),
    .cs_big  (eff_cs_big),
    .ss_big  (eff_ss_big),
    .sub64   (sub64),
    .summary (next_summary)
  );

  mcr_summary_reg u_summary (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (recompute),
    .d     (next_summary),
    .q     (summary_q)
  );

  always_comb begin
    cpl      = summary_q.cpl;
    paging   = summary_q.paging;
    prot     = summary_q.prot;
    def_op   = summary_q.def_op;
    alt_op   = summary_q.alt_op;
    def_addr = summary_q.def_addr;
    alt_addr = summary_q.alt_addr;
    stack    = summary_q.stack;
  end

endmodule

// File: rtl/mode_cache_reg_chk.sv
module mode_cache_reg_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_CR0    = 1,
  parameter int unsigned SEL_CS     = 2,
  parameter int unsigned SEL_SS     = 3,
  parameter int unsigned DPL_LSB    = 0,
  parameter int unsigned SS_BIG_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              sub64,
  input logic              lma_q,
  input logic [1:0]        cpl,
  input logic              paging,
  input logic              prot,
  input logic [1:0]        def_op,
  input logic [1:0]        alt_op,
  input logic [1:0]        def_addr,
  input logic [1:0]        alt_addr,
  input logic [1:0]        stack
);

  logic [13:0] outs;
  logic        trig;

  assign outs = {cpl, paging, prot, def_op, alt_op, def_addr, alt_addr, stack};
  assign trig = wr_en && (wr_sel == ADDR_W'(SEL_CR0) ||
                          wr_sel == ADDR_W'(SEL_CS) ||
                          wr_sel == ADDR_W'(SEL_SS));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(outs));

  p_nontrigger_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig) |=> $stable(outs));

  p_op_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (def_op != alt_op) && (def_op inside {2'd1, 2'd2}) && (alt_op inside {2'd1, 2'd2}));

  p_addr64_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (def_addr == 2'd3) |-> (alt_addr == 2'd2 && stack == 2'd3 && def_op == 2'd2));

  p_stack_ss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == ADDR_W'(SEL_SS) && lma_q && !sub64 && wr_data[SS_BIG_BIT])
      |=> (stack == 2'd2));

  p_cpl_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == ADDR_W'(SEL_CS) && lma_q)
      |=> (cpl == $past(wr_data[DPL_LSB +: 2])));

  p_lma_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !lma_q) |=> (outs == 14'b00_0_0_01_10_01_10_01));

endmodule

bind mode_cache_reg mode_cache_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_CR0(SEL_CR0), .SEL_CS(SEL_CS),
  .SEL_SS(SEL_SS), .DPL_LSB(DPL_LSB), .SS_BIG_BIT(SS_BIG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sub64(sub64), .lma_q(lma_q), .cpl(cpl), .paging(paging), .prot(prot),
  .def_op(def_op), .alt_op(alt_op), .def_addr(def_addr), .alt_addr(alt_addr),
  .stack(stack)
);

// File: tb/mode_cache_reg_bench.sv
module mode_cache_reg_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic        sub64;
  logic [1:0]  cpl, def_op, alt_op, def_addr, alt_addr, stack;
  logic        paging, prot;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench copy of the stored register bits
  logic       m_lma, m_pg, m_pe, m_csb, m_ssb;
  logic [1:0] m_dpl;
  logic [13:0] m_exp;

  mode_cache_reg u_mode_cache_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sub64(sub64), .cpl(cpl), .paging(paging),
    .prot(prot), .def_op(def_op), .alt_op(alt_op), .def_addr(def_addr),
    .alt_addr(alt_addr), .stack(stack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [13:0] RESET_VAL = {2'd0, 1'b0, 1'b0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1};

  function automatic logic [13:0] expect_of(logic lma, logic pg, logic pe,
      logic [1:0] dpl, logic csb, logic ssb, logic s64);
    logic [1:0] dop, aop, dad, aad, stk;
    if (!lma) return RESET_VAL;
    if (s64 || csb) begin dop = 2'd2; aop = 2'd1; end
    else            begin dop = 2'd1; aop = 2'd2; end
    if (s64)       begin dad = 2'd3; aad = 2'd2; end
    else if (csb)  begin dad = 2'd2; aad = 2'd1; end
    else           begin dad = 2'd1; aad = 2'd2; end
    if (s64)      stk = 2'd3;
    else if (ssb) stk = 2'd2;
    else          stk = 2'd1;
    return {dpl, pg, pe, dop, aop, dad, aad, stk};
  endfunction

  task automatic check(string req);
    logic [13:0] act;
    act = {cpl, paging, prot, def_op, alt_op, def_addr, alt_addr, stack};
    n_checks++;
    if (act !== m_exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, m_exp);
    end
  endtask

  // drive at negedge, captured at posedge, checked at following negedge
  task automatic do_write(logic [3:0] sel, logic [31:0] data, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    case (sel)
      4'd0: m_lma = data[10];
      4'd1: begin m_pg = data[31]; m_pe = data[0]; end
      4'd2: begin m_dpl = data[1:0]; m_csb = data[2]; end
      4'd3: m_ssb = data[2];
      default: ;
    endcase
    if (sel inside {4'd1, 4'd2, 4'd3})
      m_exp = expect_of(m_lma, m_pg, m_pe, m_dpl, m_csb, m_ssb, sub64);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hDEAD_BEEF; wr_sel = 4'hF;
    check(req);
  endtask

  task automatic t_reset;
    check("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  task automatic t_lma_off;
    do_write(4'd1, 32'h8000_0001, "R8 CR0 write with long mode off");
    do_write(4'd2, 32'h0000_0007, "R8 CS write with long mode off");
  endtask

  task automatic t_ext_write;
    do_write(4'd0, 32'h0000_0400, "R7 ext write no recompute");
  endtask

  task automatic t_cs_variants;
    do_write(4'd2, 32'h0000_0003, "R2 R3 R4 R5 CS dpl3 small");
    do_write(4'd2, 32'h0000_0005, "R3 R4 R6 CS big dpl1");
  endtask

  task automatic t_ss_merge;
    do_write(4'd3, 32'h0000_0004, "R5 R6 SS big keeps CS");
    do_write(4'd1, 32'h0000_0001, "R2 R6 CR0 pe only keeps CS SS");
  endtask

  task automatic t_submode;
    @(negedge clk); sub64 = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 submode change without write");
    do_write(4'd1, 32'h8000_0001, "R3 R4 R5 64-bit submode");
    @(negedge clk); sub64 = 1'b0;
    @(negedge clk);
    check("R9 submode drop without write");
    do_write(4'd3, 32'h0000_0000, "R5 R6 SS small after leaving 64-bit");
  endtask

  task automatic t_unrelated;
    do_write(4'd7, 32'hFFFF_FFFF, "R7 unrelated select 7");
    do_write(4'd15, 32'h0000_0000, "R7 unrelated select 15");
  endtask

  task automatic t_lma_clear;
    do_write(4'd0, 32'h0000_0000, "R7 ext clear no recompute");
    do_write(4'd2, 32'h0000_0006, "R8 recompute after long mode cleared");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 4'd0; wr_data = 32'd0; sub64 = 1'b0;
    m_lma = 0; m_pg = 0; m_pe = 0; m_dpl = 0; m_csb = 0; m_ssb = 0;
    m_exp = RESET_VAL;
    repeat (2) @(negedge clk);
    t_reset();
    t_lma_off();
    t_ext_write();
    t_cs_variants();
    t_ss_merge();
    t_submode();
    t_unrelated();
    t_lma_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule